// File: doc/BRIEF.md
# Serial Lane Transmit Link Controller

This block is the transmit-side link state machine for one serial lane. Per character clock it picks the octet that goes to a downstream 8b/10b encoder. It also flags whether that octet is a control character or a data character. The receiver asks for resynchronization by pulling an active-low request line low. While the request is held low, the block sends comma characters. Once the request is released, the block waits for the next multiframe boundary. It then either sends a four-multiframe lane alignment sequence or moves straight to user data.

A free-running position counter tracks the octet position within the current multiframe. A multiframe is `mf_frames` frames of 2 or 4 octets. The counter is cleared whenever a resynchronization request is seen, and again when the comma phase ends. Because of this, the first non-comma character is always octet 0 of a frame. The upstream frame assembler watches `in_data` and supplies one octet per cycle through `din` with `din_valid`.

Top module: `lane_sync_tx`

## Requirements
- R1: While `rst` is high, and on the first cycles after it, the output is the comma K28.5 (octet 0xBC, `tx_ctrl`=1) and `in_data` is 0.
- R2: A resynchronization request is recognised only when `sync_n` is sampled low on two consecutive rising edges. A single-cycle low in the alignment or data phase changes nothing at the output.
- R3: In the comma phase the output is 0xBC with `tx_ctrl`=1 on every cycle.
- R4: The comma phase ends only at the rising edge where `sync_n` is sampled high and the position counter is on the last octet of a multiframe. The next character is therefore octet 0 of a frame and of a multiframe. The position counter counts from 0 upward one per cycle after reset or after each recognised request.
- R5: With `ilas_en` nonzero, exactly four multiframes of alignment characters follow the commas, and then data. With `ilas_en` equal to 0, data follows the commas directly.
- R6: Every alignment multiframe starts with K28.0 (0x1C, `tx_ctrl`=1).
- R7: In the second alignment multiframe, position 1 carries K28.4 (0x9C, `tx_ctrl`=1). Positions 2 to 5 carry data octets in this order: F-1, K-1, `ilas_en` zero-extended, and the 8-bit sum of those three.
- R8: All other alignment positions carry the data octet equal to the low 8 bits of the position in the multiframe, with `tx_ctrl`=0.
- R9: In the data phase `in_data` is 1 and `tx_ctrl` is 0. The output octet is `din` when `din_valid` is 1, and 0x00 otherwise.
- R10: A recognised request during the alignment or data phase puts the output back to commas from the next cycle, with the position counter restarted.
- R11: A multiframe is K*F octets, where K = `mf_frames` and F = 4 when `frame_4oct` is 1 and 2 otherwise. Every alignment multiframe ends with K28.3 (0x7C, `tx_ctrl`=1) at position K*F-1. Legal settings need K*F of at least 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Character clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_n | input | 1 | Active-low resynchronization request from the receiver |
| ilas_en | input | 2 | Alignment sequence enable; any nonzero value enables it |
| mf_frames | input | 6 | Frames per multiframe (K) |
| frame_4oct | input | 1 | 1: four octets per frame, 0: two |
| din | input | 8 | Data octet from the frame assembler |
| din_valid | input | 1 | `din` holds a valid octet |
| tx_octet | output | 8 | Octet to the encoder |
| tx_ctrl | output | 1 | `tx_octet` is a control character |
| in_data | output | 1 | Data phase; `din` is consumed this cycle |

## Verification
The bench releases the request at arbitrary times and checks that the commas last exactly until the next multiframe boundary. A design that left the comma phase at once would put its first alignment or data octet in the middle of a frame. It injects single-cycle low pulses during data. A design that treated one low sample as a request would drop back to commas. It also aborts both in the middle of alignment and during data, and checks that commas restart at the very next cycle with a restarted position count. It runs several K and F settings, so that a wrong multiframe length would misplace the K28.3 end marker and the configuration block. It runs with alignment disabled, so that a design ignoring the enable would emit alignment characters where data is expected.

// File: rtl/lane_sync_pkg.sv
package lane_sync_pkg;

    typedef enum logic [1:0] {
        ST_CGS  = 2'd0,
        ST_ILAS = 2'd1,
        ST_DATA = 2'd2
    } link_state_t;

    typedef struct packed {
        logic       is_ctrl;
        logic [7:0] value;
    } lane_char_t;

    localparam logic [7:0] K28_0 = 8'h1C;
    localparam logic [7:0] K28_3 = 8'h7C;
    localparam logic [7:0] K28_4 = 8'h9C;
    localparam logic [7:0] K28_5 = 8'hBC;

    localparam int CFG_FIRST = 2;
    localparam int CFG_LEN   = 4;

    function automatic logic [7:0] cfg_octet(input logic [1:0] idx,
                                             input logic [7:0] f_m1,
                                             input logic [7:0] k_m1,
                                             input logic [1:0] en);
        logic [7:0] en8;
        en8 = {6'b0, en};
        case (idx)
            2'd0:    return f_m1;
            2'd1:    return k_m1;
            2'd2:    return en8;
            default: return f_m1 + k_m1 + en8;
        endcase
    endfunction

endpackage

// File: rtl/lane_sync_detect.sv
module lane_sync_detect (
    input  logic clk,
    input  logic rst,
    input  logic sync_n,
    output logic resync
);
    logic low_q;

    always_ff @(posedge clk) begin
        if (rst) low_q <= 1'b0;
        else     low_q <= ~sync_n;
    end

    assign resync = ~sync_n & low_q;
endmodule

// File: rtl/lane_pos_counter.sv
module lane_pos_counter #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic [PW-1:0] mf_len,
    output logic [PW-1:0] pos,
    output logic [1:0]    mf_idx,
    output logic          mf_last
);
    assign mf_last = (pos >= mf_len - PW'(1));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            pos    <= '0;
            mf_idx <= '0;
        end else if (mf_last) begin
            pos    <= '0;
            mf_idx <= mf_idx + 2'd1;
        end else begin
            pos    <= pos + PW'(1);
        end
    end

    a_r11_pos_in_range: assert property (@(posedge clk) disable iff (rst)
        pos < mf_len);
endmodule

// File: rtl/lane_ilas_gen.sv
module lane_ilas_gen
    import lane_sync_pkg::*;
#(
    parameter int KW = 6,
    parameter int PW = KW + 2
) (
    input  logic [PW-1:0] pos,
    input  logic          mf_last,
    input  logic [1:0]    mf_idx,
    input  logic [KW-1:0] mf_frames,
    input  logic          frame_4oct,
    input  logic [1:0]    ilas_en,
    output lane_char_t    ilas_char
);
    logic [7:0] f_m1;
    logic [7:0] k_m1;
    logic       in_cfg;
    logic [1:0] cfg_idx;

    assign f_m1    = frame_4oct ? 8'd3 : 8'd1;
    assign k_m1    = 8'(mf_frames) - 8'd1;
    assign in_cfg  = (mf_idx == 2'd1) && (pos >= PW'(CFG_FIRST)) &&
                     (pos < PW'(CFG_FIRST + CFG_LEN));
    assign cfg_idx = 2'(pos - PW'(CFG_FIRST));

    always_comb begin
        ilas_char = '{is_ctrl: 1'b0, value: 8'(pos)};
        if (pos == '0)
            ilas_char = '{is_ctrl: 1'b1, value: K28_0};
        else if (mf_last)
            ilas_char = '{is_ctrl: 1'b1, value: K28_3};
        else if (mf_idx == 2'd1 && pos == PW'(1))
            ilas_char = '{is_ctrl: 1'b1, value: K28_4};
        else if (in_cfg)
            ilas_char = '{is_ctrl: 1'b0,
                          value: cfg_octet(cfg_idx, f_m1, k_m1, ilas_en)};
    end
endmodule

// File: rtl/lane_sync_tx.sv
module lane_sync_tx
    import lane_sync_pkg::*;
#(
    parameter int KW = 6,
    localparam int PW = KW + 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sync_n,
    input  logic [1:0]    ilas_en,
    input  logic [KW-1:0] mf_frames,
    input  logic          frame_4oct,
    input  logic [7:0]    din,
    input  logic          din_valid,
    output logic [7:0]    tx_octet,
    output logic          tx_ctrl,
    output logic          in_data
);
    link_state_t   state;
    link_state_t   state_nx;
    logic          resync;
    logic          clear;
    logic [PW-1:0] mf_len;
    logic [PW-1:0] pos;
    logic [1:0]    mf_idx;
    logic          mf_last;
    lane_char_t    ilas_char;
    lane_char_t    out_char;

    assign mf_len = frame_4oct ? {mf_frames, 2'b00} : {1'b0, mf_frames, 1'b0};

    lane_sync_detect u_detect (
        .clk    (clk),
        .rst    (rst),
        .sync_n (sync_n),
        .resync (resync)
    );

    lane_pos_counter #(.PW(PW)) u_count (
        .clk     (clk),
        .rst     (rst),
        .clear   (clear),
        .mf_len  (mf_len),
        .pos     (pos),
        .mf_idx  (mf_idx),
        .mf_last (mf_last)
    );

    lane_ilas_gen #(.KW(KW), .PW(PW)) u_ilas (
        .pos        (pos),
        .mf_last    (mf_last),
        .mf_idx     (mf_idx),
        .mf_frames  (mf_frames),
        .frame_4oct (frame_4oct),
        .ilas_en    (ilas_en),
        .ilas_char  (ilas_char)
    );

    always_comb begin
        state_nx = state;
        clear    = 1'b0;
        if (resync) begin
            state_nx = ST_CGS;
            clear    = 1'b1;
        end else begin
            case (state)
                ST_CGS: if (sync_n && mf_last) begin
                    state_nx = (ilas_en != 2'b00) ? ST_ILAS : ST_DATA;
                    clear    = 1'b1;
                end
                ST_ILAS: if (mf_last && mf_idx == 2'd3) state_nx = ST_DATA;
                default: state_nx = state;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_CGS;
        else     state <= state_nx;
    end

    always_comb begin
        case (state)
            ST_ILAS: out_char = ilas_char;
            ST_DATA: out_char = '{is_ctrl: 1'b0, value: din_valid ? din : 8'h00};
            default: out_char = '{is_ctrl: 1'b1, value: K28_5};
        endcase
    end

    assign tx_octet = out_char.value;
    assign tx_ctrl  = out_char.is_ctrl;
    assign in_data  = (state == ST_DATA);

    a_r10_abort_to_commas: assert property (@(posedge clk) disable iff (rst)
        (!sync_n && resync) |=> (state == ST_CGS));

    a_r4_leave_on_boundary: assert property (@(posedge clk) disable iff (rst)
        (state != ST_CGS && $past(state) == ST_CGS) |-> (pos == '0 && mf_idx == 2'd0));

    a_r5_ilas_four_mf: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DATA && $past(state) == ST_ILAS) |-> ($past(mf_idx) == 2'd3 && $past(mf_last)));

    a_r5_ilas_only_enabled: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ILAS && $past(state) == ST_CGS) |-> ($past(ilas_en) != 2'b00));
endmodule

// File: tb/lane_sync_tx_bench.sv
module lane_sync_tx_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sync_n = 1'b0;
    logic [1:0] ilas_en = 2'd3;
    logic [5:0] mf_frames = 6'd8;
    logic       frame_4oct = 1'b0;
    logic [7:0] din = 8'h00;
    logic       din_valid = 1'b0;
    logic [7:0] tx_octet;
    logic       tx_ctrl;
    logic       in_data;

    int checks = 0;
    int errors = 0;

    // reference model: 0 comma, 1 alignment, 2 data
    int m_state = 0, m_pos = 0, m_mf = 0;
    bit m_prev_low = 0;
    bit f_left = 0, f_enter = 0, f_abort = 0, f_pulse = 0;
    int seed = 11;

    always #5 clk = ~clk;

    lane_sync_tx u_lane_sync_tx (
        .clk(clk), .rst(rst), .sync_n(sync_n), .ilas_en(ilas_en),
        .mf_frames(mf_frames), .frame_4oct(frame_4oct), .din(din),
        .din_valid(din_valid), .tx_octet(tx_octet), .tx_ctrl(tx_ctrl),
        .in_data(in_data)
    );

    function automatic int mf_octets();
        return int'(mf_frames) * (frame_4oct ? 4 : 2);
    endfunction

    always @(posedge clk) begin
        int len;
        bit low2;
        len = mf_octets();
        f_left = 0; f_enter = 0; f_abort = 0; f_pulse = 0;
        if (rst) begin
            m_state = 0; m_pos = 0; m_mf = 0; m_prev_low = 0;
        end else begin
            low2 = !sync_n && m_prev_low;
            f_pulse = m_prev_low && sync_n && m_state != 0;
            if (low2) begin
                if (m_state != 0) f_abort = 1;
                m_state = 0; m_pos = 0; m_mf = 0;
            end else if (m_state == 0 && sync_n && m_pos == len - 1) begin
                m_state = (ilas_en != 0) ? 1 : 2;
                f_enter = (m_state == 2);
                f_left = 1;
                m_pos = 0; m_mf = 0;
            end else begin
                if (m_state == 1 && m_pos == len - 1 && m_mf == 3) begin
                    m_state = 2; f_enter = 1;
                end
                if (m_pos == len - 1) begin
                    m_pos = 0; m_mf = (m_mf + 1) % 4;
                end else m_pos++;
            end
            m_prev_low = !sync_n;
        end
    end

    task automatic compare();
        logic [7:0] e_oct;
        logic       e_ctl;
        int         len;
        int         fm1, km1, en;
        string      tag;
        len = mf_octets();
        fm1 = frame_4oct ? 3 : 1;
        km1 = int'(mf_frames) - 1;
        en  = int'(ilas_en);
        if (m_state == 0) begin
            e_oct = 8'hBC; e_ctl = 1; tag = f_abort ? "R10" : "R3";
        end else if (m_state == 2) begin
            e_oct = din_valid ? din : 8'h00; e_ctl = 0; tag = "R9";
        end else if (m_pos == 0) begin
            e_oct = 8'h1C; e_ctl = 1; tag = "R6";
        end else if (m_pos == len - 1) begin
            e_oct = 8'h7C; e_ctl = 1; tag = "R11";
        end else if (m_mf == 1 && m_pos == 1) begin
            e_oct = 8'h9C; e_ctl = 1; tag = "R7";
        end else if (m_mf == 1 && m_pos >= 2 && m_pos <= 5) begin
            e_ctl = 0; tag = "R7";
            case (m_pos)
                2: e_oct = 8'(fm1);
                3: e_oct = 8'(km1);
                4: e_oct = 8'(en);
                default: e_oct = 8'(fm1 + km1 + en);
            endcase
        end else begin
            e_oct = 8'(m_pos); e_ctl = 0; tag = "R8";
        end
        if (rst) tag = "R1";
        else if (f_left) tag = "R4";
        else if (f_enter) tag = "R5";
        else if (f_pulse) tag = "R2";
        checks++;
        if (tx_octet !== e_oct || tx_ctrl !== e_ctl || in_data !== (m_state == 2)) begin
            errors++;
            $display("FAIL %s: octet=%h ctrl=%b in_data=%b expected octet=%h ctrl=%b in_data=%b",
                     tag, tx_octet, tx_ctrl, in_data, e_oct, e_ctl, (m_state == 2));
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare();
            seed = seed * 37 + 5;
            din = 8'(seed >> 3);
            din_valid = (seed % 5) != 0;
        end
    endtask

    task automatic run_cfg(input int k, input bit f4, input int en, input int rel);
        int len;
        rst = 1; sync_n = 0;
        mf_frames = 6'(k); frame_4oct = f4; ilas_en = 2'(en);
        step(3);
        rst = 0;
        len = k * (f4 ? 4 : 2);
        step(rel);
        sync_n = 1;                     // R4: released at arbitrary point
        step(5 * len + 10);
        sync_n = 0; step(1); sync_n = 1; // R2: single-cycle pulse
        step(len + 3);
        sync_n = 0; step(3); sync_n = 1; // R10: abort in data
        step(len + len / 2 + 2);
        sync_n = 0; step(2); sync_n = 1; // R10: abort in alignment or data
        step(6 * len);
        sync_n = 0; step(1); sync_n = 1; // R2: pulse after resync
        step(2 * len);
    endtask

    initial begin
        run_cfg(8, 0, 3, 5);
        run_cfg(16, 1, 0, 9);
        run_cfg(4, 0, 1, 3);
        run_cfg(5, 1, 2, 12);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule